// File: doc/BRIEF.md
# Parallel NOR Flash Identification Engine

This engine finds out which 8-bit parallel NOR flash device sits on an asynchronous memory bus. A single `start` pulse starts a complete probe. The engine first polls location 0 until the device stops toggling, or until a bounded number of polls has been used. It then sends a reset command and the three-write autoselect unlock. Next it reads the manufacturer byte and the device byte. It always ends with another reset, so the device is back in array-read mode afterwards.

Each ID byte must have an odd number of ones. If both bytes pass, the pair is matched against a small built-in list of known devices. The result is reported together with a one-cycle `done` pulse. It gives whether a device was recognised, the raw 16-bit ID, the device size, and the erase-sector size, with both sizes given as base-2 logarithms.

The bus side is a plain strobe/ready master. Each transaction drives one strobe, holds it until the target answers, and then releases it. Bus timing generation and interleaved multi-device arrays belong elsewhere.

Top module: `nor_id_probe`

## Requirements
- R1: After reset, and while no probe has been started, both bus strobes are low and `done` and `found` are low.
- R2: A probe starts by reading address 0 repeatedly. It moves on once two successive reads return the same byte, or once SETTLE_MAX comparison reads have been made (SETTLE_MAX+1 reads in total). Reaching the limit does not fail the probe.
- R3: Every probe, whatever its outcome, makes exactly five writes, in this order: 0xF0 to 0x555, 0xAA to 0x555, 0x55 to 0x2AA, 0x90 to 0x555, then, after the ID reads, 0xF0 to 0x555. No other data value is ever written.
- R4: Between the fourth and fifth writes the engine reads address 0 (manufacturer byte) and then address 1 (device byte), and nothing else. It reports `id` = {manufacturer, device}.
- R5: `found` is 0 when either ID byte has an even number of one bits.
- R6: The known devices are: 0x013D, 0x01AD and 0xC2AD with size_log2 21; 0x01D5 with size_log2 20; 0x01A4 and 0x20E3 with size_log2 19. All of them have sector_log2 16. An unknown or rejected ID gives `found` = 0 and both log fields = 0.
- R7: `done` is high for exactly one cycle per probe. `found`, `id`, `size_log2` and `sector_log2` are valid in that cycle and keep their values until the next probe completes.
- R8: Exactly one strobe is high per transaction. The strobe, the address and the write data stay stable until a cycle in which `bus_rdy` is high. The strobe is low in the cycle after that.
- R9: A `start` pulse while a probe is running is ignored: no second probe and no second `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Pulse that begins a probe when idle |
| bus_addr | output | ADDR_W | Bus address |
| bus_wdata | output | 8 | Bus write data |
| bus_rdata | input | 8 | Bus read data, sampled when `bus_rdy` is high |
| bus_we | output | 1 | Write strobe |
| bus_re | output | 1 | Read strobe |
| bus_rdy | input | 1 | Target completes the current transaction |
| done | output | 1 | One-cycle completion pulse |
| found | output | 1 | Known device with valid parity |
| id | output | 16 | {manufacturer, device} as read |
| size_log2 | output | 5 | log2 of device bytes, 0 if not found |
| sector_log2 | output | 5 | log2 of sector bytes, 0 if not found |

## Verification
The bench sweeps every manufacturer byte against a fixed device byte, and every device byte against a fixed manufacturer byte. This catches parity or lookup logic that accepts an even-parity byte or misses one of the six entries. The settle loop is driven with toggle runs just below, at and beyond the limit. A design with an off-by-one would make one read too many or too few, and one that treated the limit as a failure would drop a valid ID. Every probe checks the exact write log, including on rejected IDs, so a design that skips the closing reset on the failure path leaves the device in autoselect mode and shows up at once. Ready latencies of zero to three cycles and a mid-probe `start` test the strobe hold rules and the rule that a busy engine ignores `start`.

// File: rtl/nor_probe_pkg.sv
package nor_probe_pkg;

   localparam int BYTE_W  = 8;
   localparam int LOG_W   = 5;
   localparam int N_PARTS = 6;

   localparam logic [7:0] CMD_RESET = 8'hF0;
   localparam logic [7:0] CMD_KEY1  = 8'hAA;
   localparam logic [7:0] CMD_KEY2  = 8'h55;
   localparam logic [7:0] CMD_IDENT = 8'h90;

   localparam logic [10:0] LOC_KEY_A = 11'h555;
   localparam logic [10:0] LOC_KEY_B = 11'h2AA;

   typedef enum logic [3:0] {
      PS_IDLE,
      PS_SETTLE,
      PS_RESET,
      PS_KEY1,
      PS_KEY2,
      PS_IDENT,
      PS_RD_MFR,
      PS_RD_DEV,
      PS_EXIT
   } probe_state_e;

   typedef struct packed {
      logic [15:0]      code;
      logic [LOG_W-1:0] dev_log2;
      logic [LOG_W-1:0] sec_log2;
   } part_t;

   function automatic part_t part_entry(input int idx);
      part_t p;
      case (idx)
         0:       p = '{code: 16'h013D, dev_log2: 5'd21, sec_log2: 5'd16};
         1:       p = '{code: 16'h01AD, dev_log2: 5'd21, sec_log2: 5'd16};
         2:       p = '{code: 16'h01D5, dev_log2: 5'd20, sec_log2: 5'd16};
         3:       p = '{code: 16'h01A4, dev_log2: 5'd19, sec_log2: 5'd16};
         4:       p = '{code: 16'h20E3, dev_log2: 5'd19, sec_log2: 5'd16};
         5:       p = '{code: 16'hC2AD, dev_log2: 5'd21, sec_log2: 5'd16};
         default: p = '0;
      endcase
      return p;
   endfunction

   function automatic logic odd_ones(input logic [BYTE_W-1:0] b);
      return ^b;
   endfunction

endpackage

// File: rtl/nor_bus_port.sv
module nor_bus_port
   import nor_probe_pkg::*;
#(
   parameter int ADDR_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [BYTE_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic [BYTE_W-1:0] rsp_data,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [BYTE_W-1:0] bus_wdata,
   output logic              bus_we,
   output logic              bus_re,
   input  logic [BYTE_W-1:0] bus_rdata,
   input  logic              bus_rdy
);

   logic active;
   assign active = bus_we | bus_re;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bus_addr  <= '0;
         bus_wdata <= '0;
         bus_we    <= 1'b0;
         bus_re    <= 1'b0;
         rsp_valid <= 1'b0;
         rsp_data  <= '0;
      end else begin
         rsp_valid <= 1'b0;
         if (active && bus_rdy) begin
            bus_we    <= 1'b0;
            bus_re    <= 1'b0;
            rsp_valid <= 1'b1;
            rsp_data  <= bus_rdata;
         end else if (!active && req_valid) begin
            bus_addr  <= req_addr;
            bus_wdata <= req_wdata;
            bus_we    <= req_write;
            bus_re    <= !req_write;
         end
      end
   end

   // R8: strobes are mutually exclusive
   a_r8_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_we && bus_re));

   // R8: strobe, address and data hold until ready
   a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !bus_rdy) |=> ($stable(bus_we) && $stable(bus_re)
                                && $stable(bus_addr) && $stable(bus_wdata)));

   // R8: strobe released after the completing cycle
   a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
      (active && bus_rdy) |=> !active);

endmodule

// File: rtl/nor_settle_track.sv
module nor_settle_track
   import nor_probe_pkg::*;
#(
   parameter int MAX_CMP = 10000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              smp_valid,
   input  logic [BYTE_W-1:0] smp,
   output logic              settled
);

   localparam int CNT_W = $clog2(MAX_CMP + 1);
   localparam logic [CNT_W-1:0] LAST_CMP = CNT_W'(MAX_CMP - 1);

   if (MAX_CMP < 1) begin : g_bad_max
      $error("nor_settle_track: MAX_CMP must be at least 1");
   end

   logic              have_prev;
   logic [BYTE_W-1:0] prev;
   logic [CNT_W-1:0]  cmp_cnt;

   assign settled = smp_valid && have_prev && ((smp == prev) || (cmp_cnt == LAST_CMP));

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         have_prev <= 1'b0;
         prev      <= '0;
         cmp_cnt   <= '0;
      end else if (smp_valid) begin
         have_prev <= 1'b1;
         prev      <= smp;
         if (have_prev) cmp_cnt <= cmp_cnt + 1'b1;
      end
   end

   // R2: comparison count never passes its limit
   a_r2_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_cnt <= CNT_W'(MAX_CMP));

endmodule

// File: rtl/nor_id_table.sv
module nor_id_table
   import nor_probe_pkg::*;
#(
   parameter int ENTRIES = N_PARTS
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [15:0]      code,
   output logic             hit,
   output logic [LOG_W-1:0] dev_log2,
   output logic [LOG_W-1:0] sec_log2
);

   if (ENTRIES < 1 || ENTRIES > N_PARTS) begin : g_bad_entries
      $error("nor_id_table: ENTRIES out of range");
   end

   logic [ENTRIES-1:0] hit_vec;
   logic [LOG_W-1:0]   dev_vec [ENTRIES];
   logic [LOG_W-1:0]   sec_vec [ENTRIES];

   for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
      localparam part_t P = part_entry(i);
      assign hit_vec[i] = (code == P.code);
      assign dev_vec[i] = hit_vec[i] ? P.dev_log2 : '0;
      assign sec_vec[i] = hit_vec[i] ? P.sec_log2 : '0;
   end

   always_comb begin
      dev_log2 = '0;
      sec_log2 = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         dev_log2 = dev_log2 | dev_vec[i];
         sec_log2 = sec_log2 | sec_vec[i];
      end
   end

   assign hit = |hit_vec;

   // R6: entries are distinct, at most one matches
   a_r6_unique: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_vec));

endmodule

// File: rtl/nor_id_probe.sv
module nor_id_probe
   import nor_probe_pkg::*;
#(
   parameter int ADDR_W     = 12,
   parameter int SETTLE_MAX = 10000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [7:0]        bus_wdata,
   input  logic [7:0]        bus_rdata,
   output logic              bus_we,
   output logic              bus_re,
   input  logic              bus_rdy,
   output logic              done,
   output logic              found,
   output logic [15:0]       id,
   output logic [4:0]        size_log2,
   output logic [4:0]        sector_log2
);

   if (ADDR_W < 11) begin : g_bad_aw
      $error("nor_id_probe: ADDR_W must reach address 0x555");
   end
   if (BYTE_W != 8 || LOG_W != 5) begin : g_bad_width
      $error("nor_id_probe: byte and log widths are fixed");
   end

   localparam logic [ADDR_W-1:0] A_KEY_A = ADDR_W'(LOC_KEY_A);
   localparam logic [ADDR_W-1:0] A_KEY_B = ADDR_W'(LOC_KEY_B);
   localparam logic [ADDR_W-1:0] A_MFR   = ADDR_W'(0);
   localparam logic [ADDR_W-1:0] A_DEV   = ADDR_W'(1);

   probe_state_e       state_q;
   logic               issued_q;
   logic [7:0]         mfr_q;
   logic [7:0]         dev_q;

   logic               req_valid;
   logic               req_write;
   logic [ADDR_W-1:0]  req_addr;
   logic [7:0]         req_wdata;
   logic               rsp_valid;
   logic [7:0]         rsp_data;
   logic               settled;
   logic               tbl_hit;
   logic [LOG_W-1:0]   tbl_dev;
   logic [LOG_W-1:0]   tbl_sec;
   logic               id_ok;

   always_comb begin
      req_write = 1'b0;
      req_addr  = A_MFR;
      req_wdata = CMD_RESET;
      unique case (state_q)
         PS_SETTLE: begin req_write = 1'b0; req_addr = A_MFR; end
         PS_RESET:  begin req_write = 1'b1; req_addr = A_KEY_A; req_wdata = CMD_RESET; end
         PS_KEY1:   begin req_write = 1'b1; req_addr = A_KEY_A; req_wdata = CMD_KEY1;  end
         PS_KEY2:   begin req_write = 1'b1; req_addr = A_KEY_B; req_wdata = CMD_KEY2;  end
         PS_IDENT:  begin req_write = 1'b1; req_addr = A_KEY_A; req_wdata = CMD_IDENT; end
         PS_RD_MFR: begin req_write = 1'b0; req_addr = A_MFR; end
         PS_RD_DEV: begin req_write = 1'b0; req_addr = A_DEV; end
         PS_EXIT:   begin req_write = 1'b1; req_addr = A_KEY_A; req_wdata = CMD_RESET; end
         default:   begin req_write = 1'b0; req_addr = A_MFR; end
      endcase
   end

   assign req_valid = (state_q != PS_IDLE) && !issued_q;

   nor_bus_port #(.ADDR_W(ADDR_W)) u_port (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_write (req_write),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .rsp_valid (rsp_valid),
      .rsp_data  (rsp_data),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_we    (bus_we),
      .bus_re    (bus_re),
      .bus_rdata (bus_rdata),
      .bus_rdy   (bus_rdy)
   );

   nor_settle_track #(.MAX_CMP(SETTLE_MAX)) u_settle (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (state_q == PS_IDLE),
      .smp_valid (rsp_valid && (state_q == PS_SETTLE)),
      .smp       (rsp_data),
      .settled   (settled)
   );

   nor_id_table #(.ENTRIES(N_PARTS)) u_table (
      .clk      (clk),
      .rst_n    (rst_n),
      .code     ({mfr_q, dev_q}),
      .hit      (tbl_hit),
      .dev_log2 (tbl_dev),
      .sec_log2 (tbl_sec)
   );

   assign id_ok = tbl_hit && odd_ones(mfr_q) && odd_ones(dev_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q     <= PS_IDLE;
         issued_q    <= 1'b0;
         mfr_q       <= '0;
         dev_q       <= '0;
         done        <= 1'b0;
         found       <= 1'b0;
         id          <= '0;
         size_log2   <= '0;
         sector_log2 <= '0;
      end else begin
         done <= 1'b0;
         if (req_valid) issued_q <= 1'b1;
         if (state_q == PS_IDLE) begin
            issued_q <= 1'b0;
            if (start) state_q <= PS_SETTLE;
         end else if (rsp_valid) begin
            issued_q <= 1'b0;
            unique case (state_q)
               PS_SETTLE: if (settled) state_q <= PS_RESET;
               PS_RESET:  state_q <= PS_KEY1;
               PS_KEY1:   state_q <= PS_KEY2;
               PS_KEY2:   state_q <= PS_IDENT;
               PS_IDENT:  state_q <= PS_RD_MFR;
               PS_RD_MFR: begin mfr_q <= rsp_data; state_q <= PS_RD_DEV; end
               PS_RD_DEV: begin dev_q <= rsp_data; state_q <= PS_EXIT; end
               PS_EXIT: begin
                  state_q     <= PS_IDLE;
                  done        <= 1'b1;
                  found       <= id_ok;
                  id          <= {mfr_q, dev_q};
                  size_log2   <= id_ok ? tbl_dev : '0;
                  sector_log2 <= id_ok ? tbl_sec : '0;
               end
               default: state_q <= PS_IDLE;
            endcase
         end
      end
   end

   // R7: completion is a single-cycle pulse
   a_r7_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R3: only the four command bytes ever appear on a write
   a_r3_cmd_only: assert property (@(posedge clk) disable iff (!rst_n)
      bus_we |-> (bus_wdata == CMD_RESET || bus_wdata == CMD_KEY1 ||
                  bus_wdata == CMD_KEY2  || bus_wdata == CMD_IDENT));

   // R6: a recognised device reports a sector smaller than the device
   a_r6_sizes: assert property (@(posedge clk) disable iff (!rst_n)
      (done && found) |-> (size_log2 > sector_log2 && sector_log2 != 0));

   // R1/R9: no bus traffic while idle
   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PS_IDLE && $past(state_q) == PS_IDLE) |-> !(bus_we || bus_re));

endmodule

// File: tb/nor_id_probe_tb.sv
module nor_id_probe_tb;

   localparam int AW = 12;
   localparam int SM = 16;

   logic          clk = 1'b0;
   always #10 clk = ~clk;

   logic          rst_n, start;
   logic [AW-1:0] bus_addr;
   logic [7:0]    bus_wdata, bus_rdata;
   logic          bus_we, bus_re, bus_rdy;
   logic          done, found;
   logic [15:0]   id;
   logic [4:0]    size_log2, sector_log2;

   nor_id_probe #(.ADDR_W(AW), .SETTLE_MAX(SM)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .bus_we(bus_we), .bus_re(bus_re), .bus_rdy(bus_rdy),
      .done(done), .found(found), .id(id),
      .size_log2(size_log2), .sector_log2(sector_log2)
   );

   // ---------------- flash device model ----------------
   logic [7:0]    m_mfr, m_dev;
   int            m_tog, m_lat;
   logic          clr;

   logic          as_mode;
   int            unlk, wcnt, n_set, nwr, nas, viol, n_done;
   logic [AW-1:0] wla [0:7];
   logic [7:0]    wld [0:7];
   logic [AW-1:0] asa [0:3];
   logic          p_stb, p_we, p_re, p_hs;
   logic [AW-1:0] p_addr;
   logic [7:0]    p_wd;
   logic          bad;

   function automatic logic [7:0] sval(input int k, input int tog);
      if (k <= tog) return (k % 2 == 1) ? 8'h40 : 8'h00;
      return 8'h80;
   endfunction

   assign bus_rdy = (bus_we || bus_re) && (wcnt == m_lat);

   always_comb begin
      if (as_mode)
         bus_rdata = (bus_addr == 0) ? m_mfr : ((bus_addr == 1) ? m_dev : 8'h00);
      else
         bus_rdata = (bus_addr == 0) ? sval(n_set + 1, m_tog) : 8'hFF;
   end

   always_comb begin
      bad = (bus_we && bus_re)
         || (p_stb && !p_hs && ((bus_we != p_we) || (bus_re != p_re) ||
                                (bus_addr != p_addr) || (bus_we && bus_wdata != p_wd)))
         || (p_hs && (bus_we || bus_re));
   end

   always @(posedge clk) begin
      if (clr) begin
         as_mode <= 1'b0; unlk <= 0; wcnt <= 0; n_set <= 0; nwr <= 0;
         nas <= 0; viol <= 0; n_done <= 0;
         p_stb <= 1'b0; p_we <= 1'b0; p_re <= 1'b0; p_hs <= 1'b0;
         p_addr <= '0; p_wd <= '0;
      end else begin
         if (done) n_done <= n_done + 1;
         if (bad) viol <= viol + 1;
         p_stb  <= bus_we || bus_re;
         p_we   <= bus_we;
         p_re   <= bus_re;
         p_addr <= bus_addr;
         p_wd   <= bus_wdata;
         p_hs   <= bus_rdy;
         wcnt   <= ((bus_we || bus_re) && !bus_rdy) ? wcnt + 1 : 0;
         if (bus_rdy) begin
            if (bus_we) begin
               if (nwr < 8) begin wla[nwr] <= bus_addr; wld[nwr] <= bus_wdata; end
               nwr <= nwr + 1;
               if (bus_wdata == 8'hF0) begin as_mode <= 1'b0; unlk <= 0; end
               else if (unlk == 0 && bus_wdata == 8'hAA && bus_addr == 12'h555) unlk <= 1;
               else if (unlk == 1 && bus_wdata == 8'h55 && bus_addr == 12'h2AA) unlk <= 2;
               else if (unlk == 2 && bus_wdata == 8'h90 && bus_addr == 12'h555) begin
                  as_mode <= 1'b1; unlk <= 0;
               end else unlk <= 0;
            end else if (as_mode) begin
               if (nas < 4) asa[nas] <= bus_addr;
               nas <= nas + 1;
            end else if (bus_addr == 0 && nwr == 0) begin
               n_set <= n_set + 1;
            end
         end
      end
   end

   // ---------------- checking ----------------
   int n_chk = 0;
   int n_fail = 0;

   task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   function automatic logic [4:0] exp_size(input logic [15:0] code);
      case (code)
         16'h013D, 16'h01AD, 16'hC2AD: return 5'd21;
         16'h01D5:                     return 5'd20;
         16'h01A4, 16'h20E3:           return 5'd19;
         default:                      return 5'd0;
      endcase
   endfunction

   task automatic run_probe(input logic [7:0] mfr, input logic [7:0] dev,
                            input int tog, input int lat, input logic extra);
      logic        ef;
      logic [4:0]  es, ec;
      int          eset;
      int          k;
      logic [15:0] id_s;
      logic        f_s;
      @(negedge clk);
      clr = 1'b1; m_mfr = mfr; m_dev = dev; m_tog = tog; m_lat = lat;
      @(negedge clk);
      clr = 1'b0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      k = 0;
      while (!done && k < 5000) begin
         start = (extra && k == 4);
         @(negedge clk);
         k++;
      end
      start = 1'b0;
      es   = exp_size({mfr, dev});
      ef   = (^mfr) && (^dev) && (es != 0);
      ec   = ef ? 5'd16 : 5'd0;
      es   = ef ? es : 5'd0;
      eset = (tog + 2 < SM + 1) ? tog + 2 : SM + 1;
      chk(done, "R7 done seen", {31'd0, done}, 1);
      chk(found == ef, "R5/R6 found", {31'd0, found}, {31'd0, ef});
      chk(id == {mfr, dev}, "R4 id", {16'd0, id}, {16'd0, mfr, dev});
      chk(size_log2 == es, "R6 size_log2", {27'd0, size_log2}, {27'd0, es});
      chk(sector_log2 == ec, "R6 sector_log2", {27'd0, sector_log2}, {27'd0, ec});
      id_s = id; f_s = found;
      @(negedge clk);
      chk(!done, "R7 one-cycle done", {31'd0, done}, 0);
      repeat (8) @(negedge clk);
      chk(id == id_s && found == f_s, "R7 outputs held", {15'd0, found, id}, {15'd0, f_s, id_s});
      chk(!bus_we && !bus_re, "R9 no further traffic", {30'd0, bus_we, bus_re}, 0);
      chk(n_done == 1, "R9 single done", n_done, 1);
      chk(nwr == 5, "R3 write count", nwr, 5);
      chk(wla[0] == 12'h555 && wld[0] == 8'hF0, "R3 write 1", {12'd0, wla[0], wld[0]}, 32'h555F0);
      chk(wla[1] == 12'h555 && wld[1] == 8'hAA, "R3 write 2", {12'd0, wla[1], wld[1]}, 32'h555AA);
      chk(wla[2] == 12'h2AA && wld[2] == 8'h55, "R3 write 3", {12'd0, wla[2], wld[2]}, 32'h2AA55);
      chk(wla[3] == 12'h555 && wld[3] == 8'h90, "R3 write 4", {12'd0, wla[3], wld[3]}, 32'h55590);
      chk(wla[4] == 12'h555 && wld[4] == 8'hF0, "R3 write 5", {12'd0, wla[4], wld[4]}, 32'h555F0);
      chk(nas == 2, "R4 autoselect reads", nas, 2);
      chk(asa[0] == 0 && asa[1] == 1, "R4 read order", {8'd0, asa[0], asa[1]}, 32'h1);
      chk(n_set == eset, "R2 settle reads", n_set, eset);
      chk(viol == 0, "R8 handshake rules", viol, 0);
   endtask

   initial begin
      logic [15:0] known [6];
      known = '{16'h013D, 16'h01AD, 16'h01D5, 16'h01A4, 16'h20E3, 16'hC2AD};
      rst_n = 1'b0; start = 1'b0; clr = 1'b1;
      m_mfr = 8'h01; m_dev = 8'h3D; m_tog = 0; m_lat = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!bus_we && !bus_re, "R1 strobes after reset", {30'd0, bus_we, bus_re}, 0);
      chk(!done && !found, "R1 outputs after reset", {30'd0, done, found}, 0);
      clr = 1'b0;
      repeat (6) @(negedge clk);
      chk(!bus_we && !bus_re && nwr == 0, "R1 idle without start", nwr, 0);

      // R6: every known device at each ready latency
      for (int i = 0; i < 6; i++)
         for (int l = 0; l < 4; l++)
            run_probe(known[i][15:8], known[i][7:0], 1, l, 1'b0);

      // R5/R6: sweep manufacturer byte, then device byte
      for (int v = 0; v < 256; v++)
         run_probe(v[7:0], 8'hAD, 0, v % 3, 1'b0);
      for (int v = 0; v < 256; v++)
         run_probe(8'hC2, v[7:0], 0, (v + 1) % 3, 1'b0);

      // R2: settle runs around the limit, including timeout
      for (int t = 0; t <= SM + 4; t++)
         run_probe(8'h01, 8'hA4, t, 1, 1'b0);
      run_probe(8'h20, 8'hE3, 200, 2, 1'b0);

      // R9: start during a running probe
      run_probe(8'h01, 8'hD5, 3, 2, 1'b1);
      run_probe(8'h13, 8'h37, 5, 0, 1'b1);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(20 * 190000);
      $display("FAIL R7 watchdog: done actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail + 1);
      $finish;
   end

endmodule